// File: doc/BRIEF.md
# Burst Write/Read-Back Memory Test Sequencer

This block runs one self-contained memory test through the user side of a multi-port DRAM controller. It waits for the controller to report that calibration has finished. A single-cycle trigger then starts a run. The block pushes a burst of 64-bit pattern words into the controller's write data FIFO. Once the whole burst is loaded, it issues a write command, then a read command to the same aligned byte address. It then pops the returned words from the read data FIFO and compares each one with the pattern it wrote.

The result is a `done` level, a `pass` level and a sticky `err` flag. Another trigger after `done` starts a fresh run. The error flag survives that rerun and is cleared only by reset. The controller, the DRAM pins and the calibration machinery are not part of this block.

Top module: `burst_wr_rd_tester`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `wr_en`, `cmd_en`, `rd_en`, `done`, `pass` and `err` are all 0.
- R2: No write, command or read enable is raised until `calib_done` has been seen high. A `trig` pulse that arrives before that is dropped, so no run starts later unless a new trigger arrives.
- R3: A trigger in the ready state loads exactly `BURST_WORDS` words (default 16). A word counts only on an edge where `wr_en`=1 and `wr_full`=0. `wr_mask` is all zero, where a 1 bit would mask a byte.
- R4: Word i of a burst is {key ^ 32'h5A5A5A5A, key}, where key = (zero-extended 32-bit command address) + i. The key occupies bits 31:0.
- R5: The write command is pushed only after every burst word has been accepted. `cmd_en` is raised only while `cmd_full` is 0. Each run pushes exactly one write command, followed by one read command.
- R6: In the command word, `cmd_instr` bit 0 is 1 for read and 0 for write. Bit 1 is auto-precharge and equals parameter `AUTO_PRE` (default 0). Bit 2, the refresh request, is always 0. `cmd_bl` holds `BURST_WORDS`-1.
- R7: `cmd_byte_addr` equals `base_addr` (sampled with the trigger) with its low three bits cleared. Both commands of a run carry the same address.
- R8: The read FIFO shows its head word on `rd_data` while `rd_empty` is 0. `rd_en` is raised only while `rd_empty` is 0. Exactly `BURST_WORDS` words are popped, and each is compared with the R4 pattern for its index.
- R9: A mismatch on any popped word sets `err` on the next edge. `err` stays set until reset. `pass` = `done` and not `err`.
- R10: `done` rises after the last word is popped and holds. A `trig` while `done` is high starts a new run, and `done` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| calib_done | input | 1 | Controller calibration complete |
| trig | input | 1 | Single-cycle start pulse |
| base_addr | input | 30 | Byte address of the test burst |
| cmd_en | output | 1 | Push command into command FIFO |
| cmd_instr | output | 3 | Instruction: bit0 read, bit1 auto-precharge, bit2 refresh |
| cmd_bl | output | 6 | Burst length minus one |
| cmd_byte_addr | output | 30 | Aligned byte start address |
| cmd_full | input | 1 | Command FIFO full |
| wr_en | output | 1 | Write data FIFO push request |
| wr_mask | output | 8 | Byte mask, 1 = masked |
| wr_data | output | 64 | Write data word |
| wr_full | input | 1 | Write data FIFO full |
| rd_en | output | 1 | Read data FIFO pop |
| rd_data | input | 64 | Read FIFO head word |
| rd_empty | input | 1 | Read data FIFO empty |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished without mismatch |
| err | output | 1 | Sticky mismatch flag |

## Verification
A trigger before calibration is the first trap: a sequencer that latched it would start writing as soon as calibration arrived. Throttling on the full and empty flags is the second, and the bench toggles all three while a burst is in flight. A design that counted a word during a full cycle would come up short. A design that popped an empty FIFO would compare stale data. An unaligned base address exposes a missing alignment mask. A single corrupted read word, followed by a clean rerun, exposes a flag that was not sticky or a `pass` that ignored it.

// File: rtl/bst_pkg.sv
package bst_pkg;
    localparam int PORT_W     = 64;
    localparam int MASK_W     = 8;
    localparam int BL_W       = 6;
    localparam int ADDR_W     = 30;
    localparam int KEY_W      = PORT_W / 2;
    localparam int ALIGN_BITS = $clog2(MASK_W);
    localparam logic [KEY_W-1:0] PAT_XOR = 32'h5A5A_5A5A;

    typedef enum logic [2:0] {
        S_IDLE, S_WAIT_CAL, S_WAIT_TRIG, S_FILL,
        S_WR_CMD, S_RD_CMD, S_DRAIN, S_DONE
    } state_e;

    typedef struct packed {
        logic refresh;   // bit 2
        logic auto_pre;  // bit 1
        logic is_read;   // bit 0
    } instr_t;

    typedef struct packed {
        instr_t            instr;
        logic [BL_W-1:0]   bl;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    function automatic logic [ADDR_W-1:0] align_addr(logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    endfunction

    function automatic logic [PORT_W-1:0] pattern_word(logic [ADDR_W-1:0] a,
                                                       logic [BL_W-1:0] idx);
        logic [KEY_W-1:0] key;
        key = KEY_W'(a) + KEY_W'(idx);
        return {key ^ PAT_XOR, key};
    endfunction
endpackage

// File: rtl/bst_word_ctr.sv
module bst_word_ctr
    import bst_pkg::*;
#(
    parameter int N = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            step,
    output logic [BL_W-1:0] idx,
    output logic            last
);
    localparam logic [BL_W-1:0] LAST_IDX = BL_W'(N - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) idx <= '0;
        else if (step)  idx <= idx + 1'b1;
    end

    assign last = (idx == LAST_IDX);
endmodule

// File: rtl/bst_cmd_pack.sv
module bst_cmd_pack
    import bst_pkg::*;
#(
    parameter int BURST_WORDS = 16,
    parameter bit AUTO_PRE    = 1'b0
) (
    input  logic              is_read,
    input  logic [ADDR_W-1:0] addr,
    output cmd_t              cmd
);
    always_comb begin
        cmd.instr.refresh  = 1'b0;
        cmd.instr.auto_pre = AUTO_PRE;
        cmd.instr.is_read  = is_read;
        cmd.bl             = BL_W'(BURST_WORDS - 1);
        cmd.addr           = addr;
    end
endmodule

// File: rtl/bst_rd_cmp.sv
module bst_rd_cmp
    import bst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pop,
    input  logic [PORT_W-1:0] got,
    input  logic [PORT_W-1:0] want,
    output logic              err
);
    always_ff @(posedge clk) begin
        if (rst)                        err <= 1'b0;
        else if (pop && (got != want))  err <= 1'b1;
    end
endmodule

// File: rtl/burst_wr_rd_tester.sv
module burst_wr_rd_tester
    import bst_pkg::*;
#(
    parameter int BURST_WORDS = 16,
    parameter bit AUTO_PRE    = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              calib_done,
    input  logic              trig,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              cmd_en,
    output logic [2:0]        cmd_instr,
    output logic [BL_W-1:0]   cmd_bl,
    output logic [ADDR_W-1:0] cmd_byte_addr,
    input  logic              cmd_full,
    output logic              wr_en,
    output logic [MASK_W-1:0] wr_mask,
    output logic [PORT_W-1:0] wr_data,
    input  logic              wr_full,
    output logic              rd_en,
    input  logic [PORT_W-1:0] rd_data,
    input  logic              rd_empty,
    output logic              done,
    output logic              pass,
    output logic              err
);
    state_e            state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              go, fill_step, pop, cmd_push;
    logic [BL_W-1:0]   fill_idx, drain_idx;
    logic              fill_last, drain_last;
    cmd_t              cmd;

    assign go        = trig && (state_q == S_WAIT_TRIG || state_q == S_DONE);
    assign wr_en     = (state_q == S_FILL);
    assign fill_step = wr_en && !wr_full;
    assign cmd_push  = (state_q == S_WR_CMD || state_q == S_RD_CMD) && !cmd_full;
    assign cmd_en    = cmd_push;
    assign pop       = (state_q == S_DRAIN) && !rd_empty;
    assign rd_en     = pop;
    assign wr_mask   = '0;
    assign wr_data   = pattern_word(addr_q, fill_idx);
    assign done      = (state_q == S_DONE);
    assign pass      = done && !err;

    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:      state_d = S_WAIT_CAL;
            S_WAIT_CAL:  if (calib_done) state_d = S_WAIT_TRIG;
            S_WAIT_TRIG: if (trig) state_d = S_FILL;
            S_FILL:      if (fill_step && fill_last) state_d = S_WR_CMD;
            S_WR_CMD:    if (!cmd_full) state_d = S_RD_CMD;
            S_RD_CMD:    if (!cmd_full) state_d = S_DRAIN;
            S_DRAIN:     if (pop && drain_last) state_d = S_DONE;
            S_DONE:      if (trig) state_d = S_FILL;
            default:     state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (go) addr_q <= align_addr(base_addr);
        end
    end

    bst_word_ctr #(.N(BURST_WORDS)) u_fill_ctr (
        .clk(clk), .rst(rst), .clr(go), .step(fill_step),
        .idx(fill_idx), .last(fill_last)
    );

    bst_word_ctr #(.N(BURST_WORDS)) u_drain_ctr (
        .clk(clk), .rst(rst), .clr(go), .step(pop),
        .idx(drain_idx), .last(drain_last)
    );

    bst_cmd_pack #(.BURST_WORDS(BURST_WORDS), .AUTO_PRE(AUTO_PRE)) u_pack (
        .is_read(state_q == S_RD_CMD), .addr(addr_q), .cmd(cmd)
    );

    assign cmd_instr     = cmd.instr;
    assign cmd_bl        = cmd.bl;
    assign cmd_byte_addr = cmd.addr;

    bst_rd_cmp u_cmp (
        .clk(clk), .rst(rst), .pop(pop), .got(rd_data),
        .want(pattern_word(addr_q, drain_idx)), .err(err)
    );
endmodule

// File: rtl/bst_checker.sv
module bst_checker
    import bst_pkg::*;
#(
    parameter int BURST_WORDS = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              calib_done,
    input logic              cmd_en,
    input logic [2:0]        cmd_instr,
    input logic [BL_W-1:0]   cmd_bl,
    input logic [ADDR_W-1:0] cmd_byte_addr,
    input logic              cmd_full,
    input logic              wr_en,
    input logic [MASK_W-1:0] wr_mask,
    input logic              rd_en,
    input logic              rd_empty,
    input logic              done,
    input logic              err
);
    logic cal_seen;
    always_ff @(posedge clk) begin
        if (rst)             cal_seen <= 1'b0;
        else if (calib_done) cal_seen <= 1'b1;
    end

    AST_NO_EARLY_ACT: assert property (@(posedge clk) disable iff (rst)
        !cal_seen |-> !(wr_en || cmd_en || rd_en)); // R2
    AST_WR_MASK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_mask == '0)); // R3
    AST_CMD_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
        cmd_en |-> !cmd_full); // R5
    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, cmd_en, rd_en})); // R5
    AST_CMD_FIELDS: assert property (@(posedge clk) disable iff (rst)
        cmd_en |-> (!cmd_instr[2] && cmd_bl == BL_W'(BURST_WORDS - 1))); // R6
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        cmd_en |-> (cmd_byte_addr[ALIGN_BITS-1:0] == '0)); // R7
    AST_RD_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !rd_empty); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R9
    AST_DONE_IDLE_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !(wr_en || cmd_en || rd_en)); // R10
endmodule

bind burst_wr_rd_tester bst_checker #(.BURST_WORDS(BURST_WORDS)) u_chk (
    .clk(clk), .rst(rst), .calib_done(calib_done), .cmd_en(cmd_en),
    .cmd_instr(cmd_instr), .cmd_bl(cmd_bl), .cmd_byte_addr(cmd_byte_addr),
    .cmd_full(cmd_full), .wr_en(wr_en), .wr_mask(wr_mask), .rd_en(rd_en),
    .rd_empty(rd_empty), .done(done), .err(err)
);

// File: tb/sim_burst_wr_rd_tester.sv
`timescale 1ns/1ps
module sim_burst_wr_rd_tester;
    localparam int BW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        calib_done = 1'b0;
    logic        trig = 1'b0;
    logic [29:0] base_addr = '0;
    logic        cmd_en, wr_en, rd_en, done, pass, err;
    logic [2:0]  cmd_instr;
    logic [5:0]  cmd_bl;
    logic [29:0] cmd_byte_addr;
    logic [7:0]  wr_mask;
    logic [63:0] wr_data, rd_data;
    logic        cmd_full, wr_full, rd_empty;

    always #2 clk = ~clk;

    burst_wr_rd_tester u0 (
        .clk(clk), .rst(rst), .calib_done(calib_done), .trig(trig),
        .base_addr(base_addr), .cmd_en(cmd_en), .cmd_instr(cmd_instr),
        .cmd_bl(cmd_bl), .cmd_byte_addr(cmd_byte_addr), .cmd_full(cmd_full),
        .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data), .wr_full(wr_full),
        .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty),
        .done(done), .pass(pass), .err(err)
    );

    // ---- behavioural controller port model ----
    logic [63:0] mem [0:255];
    logic [63:0] wq [0:63];
    logic [63:0] rq [0:63];
    int wq_n = 0, rq_h = 0, rq_n = 0, cyc = 0;
    int cmd_cnt = 0, mism = 0, mask_bad = 0, pops = 0, early = 0;
    bit cal_seen = 0, bp_en = 0;
    int corrupt_idx = -1;
    logic [29:0] exp_addr = '0;
    logic [2:0]  log_instr [0:15];
    logic [5:0]  log_bl [0:15];
    logic [29:0] log_addr [0:15];
    int          log_wq [0:15];

    function automatic logic [63:0] exp_word(logic [29:0] a, int i);
        logic [31:0] k;
        k = {2'b00, a} + 32'(i);
        return {k ^ 32'h5A5A5A5A, k};
    endfunction

    assign wr_full  = bp_en && (cyc % 3 == 0);
    assign cmd_full = bp_en && (cyc % 4 != 3);
    assign rd_empty = (rq_h >= rq_n) || (bp_en && (cyc % 2 == 1));
    assign rd_data  = rq[rq_h[5:0]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (calib_done) cal_seen <= 1;
        if (!cal_seen && (wr_en || cmd_en || rd_en)) early <= early + 1;
        if (wr_en && !wr_full) begin
            if (wr_data != exp_word(exp_addr, wq_n)) mism <= mism + 1;
            if (wr_mask != 0) mask_bad <= mask_bad + 1;
            wq[wq_n[5:0]] <= wr_data;
            wq_n <= wq_n + 1;
        end
        if (cmd_en && !cmd_full) begin
            log_instr[cmd_cnt % 16] <= cmd_instr;
            log_bl[cmd_cnt % 16]    <= cmd_bl;
            log_addr[cmd_cnt % 16]  <= cmd_byte_addr;
            log_wq[cmd_cnt % 16]    <= wq_n;
            cmd_cnt <= cmd_cnt + 1;
            if (!cmd_instr[0]) begin
                for (int i = 0; i < 64; i++)
                    if (i <= int'(cmd_bl)) mem[((cmd_byte_addr >> 3) + 30'(i)) & 30'hFF] <= wq[i];
                wq_n <= 0;
            end else begin
                for (int i = 0; i < 64; i++)
                    if (i <= int'(cmd_bl))
                        rq[i] <= mem[((cmd_byte_addr >> 3) + 30'(i)) & 30'hFF]
                                 ^ ((i == corrupt_idx) ? 64'h2_0000 : 64'h0);
                rq_n <= int'(cmd_bl) + 1;
                rq_h <= 0;
            end
        end
        if (rd_en && !rd_empty) begin
            rq_h <= rq_h + 1;
            pops <= pops + 1;
        end
    end

    // ---- checking helpers ----
    int total = 0, bad = 0;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic pulse_trig();
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            if (done) return;
            @(negedge clk);
        end
    endtask

    task automatic run_and_check(string tag, logic [29:0] ba, logic [29:0] ea);
        int c0, m0, p0;
        c0 = cmd_cnt; m0 = mism; p0 = pops;
        base_addr = ba; exp_addr = ea;
        pulse_trig();
        wait_done();
        chk(done == 1, {tag, " R10 done"}, done, 1);
        chk(cmd_cnt - c0 == 2, {tag, " R5 two commands"}, cmd_cnt - c0, 2);
        chk(log_instr[c0 % 16] == 3'b000, {tag, " R6 write instr"}, log_instr[c0 % 16], 0);
        chk(log_instr[(c0 + 1) % 16] == 3'b001, {tag, " R6 read instr"}, log_instr[(c0 + 1) % 16], 1);
        chk(log_bl[c0 % 16] == 6'(BW - 1) && log_bl[(c0 + 1) % 16] == 6'(BW - 1),
            {tag, " R6 burst length"}, log_bl[c0 % 16], BW - 1);
        chk(log_addr[c0 % 16] == ea && log_addr[(c0 + 1) % 16] == ea,
            {tag, " R7 address"}, log_addr[(c0 + 1) % 16], ea);
        chk(log_wq[c0 % 16] == BW, {tag, " R3 R5 words before write cmd"}, log_wq[c0 % 16], BW);
        chk(mism == m0, {tag, " R4 write pattern"}, mism - m0, 0);
        chk(pops - p0 == BW, {tag, " R8 words popped"}, pops - p0, BW);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!wr_en && !cmd_en && !rd_en, "R1 enables in reset", {wr_en, cmd_en, rd_en}, 0);
        chk(!done && !pass && !err, "R1 status in reset", {done, pass, err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!wr_en && !cmd_en && !rd_en && !done && !err, "R1 after reset",
            {wr_en, cmd_en, rd_en, done, err}, 0);
    endtask

    task automatic t_early_trig();
        pulse_trig();
        repeat (10) @(negedge clk);
        chk(cmd_cnt == 0 && wq_n == 0, "R2 no action before calibration", cmd_cnt + wq_n, 0);
        calib_done = 1'b1;
        repeat (20) @(negedge clk);
        chk(cmd_cnt == 0 && wq_n == 0 && !done, "R2 early trigger dropped", cmd_cnt + wq_n, 0);
        chk(early == 0, "R2 early enable", early, 0);
    endtask

    task automatic t_basic();
        run_and_check("basic", 30'h100, 30'h100);
        chk(pass && !err, "R9 pass on clean run", {pass, err}, 2'b10);
        chk(mask_bad == 0, "R3 mask zero", mask_bad, 0);
        repeat (5) @(negedge clk);
        chk(done == 1, "R10 done holds", done, 1);
    endtask

    task automatic t_backpressure_unaligned();
        bp_en = 1;
        run_and_check("bp", 30'h1235, 30'h1230);
        chk(pass, "R8 pass under throttling", pass, 1);
        bp_en = 0;
    endtask

    task automatic t_corrupt();
        corrupt_idx = 5;
        run_and_check("corrupt", 30'h40, 30'h40);
        chk(err && !pass, "R9 mismatch flagged", {err, pass}, 2'b10);
        corrupt_idx = -1;
    endtask

    task automatic t_sticky_rerun();
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        chk(done == 0, "R10 done clears on retrigger", done, 0);
        wait_done();
        chk(done && err && !pass, "R9 error sticky across rerun", {done, err, pass}, 3'b110);
    endtask

    task automatic t_reset_clears();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk(!err && !done, "R9 reset clears error", {err, done}, 0);
        repeat (3) @(negedge clk);
        run_and_check("after reset", 30'h208, 30'h208);
        chk(pass, "R9 pass after reset", pass, 1);
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_early_trig();
        t_basic();
        t_backpressure_unaligned();
        t_corrupt();
        t_sticky_rerun();
        t_reset_clears();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule